// File: doc/BRIEF.md
# DCO reference selection controller

This block decides what the digitally controlled oscillator of a receive jitter attenuator follows. There are three choices: the recovered line clock, an external sync input, or no reference at all (free run). The block also measures phase error against a divided copy of the oscillator output clock, keeps a running sum of that error, and asks for the oscillator to be re-centred when the chosen reference goes quiet. Everything runs in the oscillator output clock domain, which is the `clk` port.

The reference edges arrive on `line_edge` and `sync_edge`. Each is a one-cycle strobe, already synchronized, marking one reference period. A free-running divider counts output clock cycles modulo a ratio. The ratio follows the selected frequency, so every reference is compared with a divided clock of the same rate. At each selected reference edge the divider position is turned into a signed error.

Phase-error results leave on a valid/ready stream made of `phase_valid`, `phase_ready` and `phase_err`. A result stays on the port, unchanged, until it is accepted. While a result is waiting, new reference edges produce no result and are dropped. The block does not buffer results. All other pins are plain levels.

Top module: `dco_ref_sel_ctl`

## Requirements
- R1: With `mode_master`=0 and `los`=0, `ref_sel` becomes 0 (line clock) one clock after the inputs are applied.
- R2: With `mode_master`=0, `los`=1 and `no_autosw`=0, the selection follows master behaviour: `ref_sel`=1 (sync) if the sync input is present, otherwise 2 (free run).
- R3: With `mode_master`=0 and `no_autosw`=1, `ref_sel` stays 0 whatever `los` holds.
- R4: With `mode_master`=1, `ref_sel`=1 if the sync input is present, otherwise 2. `free_run` is 1 exactly when `ref_sel`=2.
- R5: The sync input becomes present at the clock edge that samples a `sync_edge` strobe. It becomes absent at the edge SYNC_WIN cycles after the last strobe if no strobe has come by then. Strobes spaced exactly SYNC_WIN cycles apart keep it present.
- R6: The divider ratio R is DIV_8K when the sync reference is selected and `fsel_8k`=1. Otherwise R is DIV_E1 if `fsel_e1`=1, else DIV_T1. `fsel_8k` has no effect on the line reference. After reset, the divider position at the k-th sampling edge is k mod R. The error for an edge sampled at position p is p when p < R/2 (integer division), and p-R otherwise.
- R7: A reference edge accepted at a clock edge raises `phase_valid` after that edge, with `phase_err` set to the error. While `phase_ready`=0 the valid result and its value are held, and further reference edges are dropped. With `phase_ready`=1 and no new edge, `phase_valid` falls at the next clock edge.
- R8: With `center_dis`=0, `recenter` goes to 1 once GAP_PERIODS divider wraps have passed after the last selected reference edge with no new edge. A wrap is the clock edge at which the divider is at position R-1. With `center_dis`=1, `recenter` is 0.
- R9: In free run (`ref_sel`=2), `recenter` is 1 when `center_dis`=0 and 0 when `center_dis`=1.
- R10: Any change of `ref_sel` clears `phase_acc` and drops `phase_valid`. The first selected reference edge after the change produces no result.
- R11: `phase_acc` is the two's-complement sum of all errors emitted on `phase_err` since reset or since the last change of selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator output clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_master | input | 1 | 1 = master (sync or free run), 0 = slave (line clock) |
| no_autosw | input | 1 | 1 = loss of signal does not leave the line clock |
| fsel_e1 | input | 1 | Rate select: 0 = 1.544 MHz, 1 = 2.048 MHz |
| fsel_8k | input | 1 | 1 = sync input runs at 8 kHz |
| center_dis | input | 1 | 1 = no re-centering (a gapped reference is accepted) |
| los | input | 1 | Loss of signal on the line |
| line_edge | input | 1 | One-cycle strobe per recovered line clock period |
| sync_edge | input | 1 | One-cycle strobe per sync input period |
| phase_ready | input | 1 | Downstream accepts the phase-error result |
| ref_sel | output | 2 | 0 = line, 1 = sync, 2 = free run |
| free_run | output | 1 | Oscillator has no reference |
| recenter | output | 1 | Request to hold the oscillator centred |
| phase_valid | output | 1 | Phase-error result valid |
| phase_err | output | ERR_W | Signed phase error in output clock cycles |
| phase_acc | output | ACC_W | Signed running sum of emitted errors |

## Verification
The bench walks all 32 combinations of mode, loss of signal, auto-switch disable, sync presence and centering disable. A wrong priority between the mode bit and the loss-of-signal path would show up as the line clock kept when it should be left, or left when it should be kept. It also places a reference edge at every divider position for every ratio. An off-by-one in the divider or in the signed fold at R/2 would give errors shifted by a cycle or of the wrong sign, and an 8 kHz select that leaks into the line path would give the wrong modulus. The sync window is probed at exactly SYNC_WIN and SYNC_WIN+1 cycles, where a design with the wrong count would drop the sync input one cycle early or late. The bench also checks back-pressure hold and blanking after a change of selection, where a careless design would overwrite a held result or emit an error on the first edge after the switch.

// File: rtl/dco_ref_pkg.sv
package dco_ref_pkg;
  typedef enum logic [1:0] {
    REF_LINE = 2'd0,
    REF_SYNC = 2'd1,
    REF_FREE = 2'd2
  } ref_sel_e;
endpackage

// File: rtl/dco_sync_detect.sv
// Presence detector for the external sync input: a window counter restarted by each strobe.
module dco_sync_detect #(
  parameter int SYNC_WIN = 2048
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_edge,
  output logic present
);
  localparam int CW = $clog2(SYNC_WIN + 1);

  logic [CW-1:0] age;

  always_ff @(posedge clk) begin
    if (rst) begin
      age     <= '0;
      present <= 1'b0;
    end else if (sync_edge) begin
      age     <= CW'(1);
      present <= 1'b1;
    end else if (present) begin
      if (age == CW'(SYNC_WIN)) present <= 1'b0;
      else                      age     <= age + CW'(1);
    end
  end

  p_edge_sets_r5: assert property (@(posedge clk) disable iff (rst)
    sync_edge |=> present);
  p_window_expiry_r5: assert property (@(posedge clk) disable iff (rst)
    (present && !sync_edge && age == CW'(SYNC_WIN)) |=> !present);
endmodule

// File: rtl/dco_ref_select.sv
// Reference choice from mode, loss of signal and sync presence; divider ratio for the chosen rate.
module dco_ref_select
  import dco_ref_pkg::*;
#(
  parameter int DIV_T1 = 8,
  parameter int DIV_E1 = 6,
  parameter int DIV_8K = 64,
  parameter int RW     = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_master,
  input  logic          no_autosw,
  input  logic          los,
  input  logic          sync_present,
  input  logic          fsel_e1,
  input  logic          fsel_8k,
  output ref_sel_e      sel,
  output logic          sel_chg,
  output logic [RW-1:0] ratio
);
  logic     use_master;
  ref_sel_e sel_d;
  logic [RW-1:0] line_ratio;

  assign use_master = mode_master | (los & ~no_autosw);

  always_comb begin
    if (!use_master)       sel_d = REF_LINE;
    else if (sync_present) sel_d = REF_SYNC;
    else                   sel_d = REF_FREE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel     <= REF_LINE;
      sel_chg <= 1'b0;
    end else begin
      sel     <= sel_d;
      sel_chg <= (sel_d != sel);
    end
  end

  assign line_ratio = fsel_e1 ? RW'(DIV_E1) : RW'(DIV_T1);
  assign ratio      = (sel == REF_SYNC && fsel_8k) ? RW'(DIV_8K) : line_ratio;

  p_slave_line_r1: assert property (@(posedge clk) disable iff (rst)
    (!mode_master && !los) |=> sel == REF_LINE);
  p_los_fallback_r2: assert property (@(posedge clk) disable iff (rst)
    (!mode_master && los && !no_autosw) |=> sel != REF_LINE);
  p_no_autosw_r3: assert property (@(posedge clk) disable iff (rst)
    (!mode_master && no_autosw) |=> sel == REF_LINE);
  p_master_free_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_master && !sync_present) |=> sel == REF_FREE);
endmodule

// File: rtl/dco_phase_cmp.sv
// Divided-clock phase comparator with accumulator, change blanking and a held valid/ready result.
module dco_phase_cmp
  import dco_ref_pkg::*;
#(
  parameter int RW    = 7,
  parameter int ERR_W = 8,
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [RW-1:0]    ratio,
  input  ref_sel_e         sel,
  input  logic             sel_chg,
  input  logic             line_edge,
  input  logic             sync_edge,
  input  logic             ready,
  output logic             wrap,
  output logic             ref_edge,
  output logic             valid,
  output logic [ERR_W-1:0] err,
  output logic [ACC_W-1:0] acc
);
  logic [RW-1:0]    div_cnt;
  logic [RW-1:0]    half;
  logic [ERR_W-1:0] err_now;
  logic [ACC_W-1:0] err_ext;
  logic             blank;

  assign wrap     = (div_cnt >= ratio - RW'(1));
  assign half     = ratio >> 1;
  assign ref_edge = (sel == REF_LINE) ? line_edge :
                    (sel == REF_SYNC) ? sync_edge : 1'b0;
  assign err_now  = (div_cnt < half) ? {1'b0, div_cnt}
                                     : ({1'b0, div_cnt} - {1'b0, ratio});
  assign err_ext  = {{(ACC_W-ERR_W){err_now[ERR_W-1]}}, err_now};

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      valid   <= 1'b0;
      err     <= '0;
      acc     <= '0;
      blank   <= 1'b0;
    end else begin
      div_cnt <= wrap ? '0 : div_cnt + RW'(1);
      if (sel_chg) begin
        valid <= 1'b0;
        acc   <= '0;
        blank <= 1'b1;
      end else begin
        if (valid && ready) valid <= 1'b0;
        if (ref_edge) begin
          if (blank) begin
            blank <= 1'b0;
          end else if (!valid || ready) begin
            valid <= 1'b1;
            err   <= err_now;
            acc   <= acc + err_ext;
          end
        end
      end
    end
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready && !sel_chg) |=> (valid && $stable(err)));
  p_chg_drop_r10: assert property (@(posedge clk) disable iff (rst)
    sel_chg |=> (!valid && acc == '0));
  p_blank_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    blank |-> !valid);
endmodule

// File: rtl/dco_center_ctl.sv
// Re-center request: free run, or too many reference periods without a selected edge.
module dco_center_ctl
  import dco_ref_pkg::*;
#(
  parameter int GAP_PERIODS = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     wrap,
  input  logic     ref_edge,
  input  logic     sel_chg,
  input  ref_sel_e sel,
  input  logic     center_dis,
  output logic     recenter
);
  localparam int GW = $clog2(GAP_PERIODS + 1);

  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst)                                    gap <= '0;
    else if (ref_edge || sel_chg)               gap <= '0;
    else if (wrap && gap != GW'(GAP_PERIODS))   gap <= gap + GW'(1);
  end

  assign recenter = !center_dis && (sel == REF_FREE || gap == GW'(GAP_PERIODS));

  p_edge_restarts_r8: assert property (@(posedge clk) disable iff (rst)
    ref_edge |=> gap == '0);
  p_gap_bound_r8: assert property (@(posedge clk) disable iff (rst)
    gap <= GW'(GAP_PERIODS));
endmodule

// File: rtl/dco_ref_sel_ctl.sv
module dco_ref_sel_ctl
  import dco_ref_pkg::*;
#(
  parameter int SYNC_WIN    = 2048,
  parameter int DIV_T1      = 8,
  parameter int DIV_E1      = 6,
  parameter int DIV_8K      = 64,
  parameter int GAP_PERIODS = 4,
  parameter int ACC_W       = 16,
  localparam int DMAX  = (DIV_8K > DIV_E1) ? ((DIV_8K > DIV_T1) ? DIV_8K : DIV_T1)
                                           : ((DIV_E1 > DIV_T1) ? DIV_E1 : DIV_T1),
  localparam int RW    = $clog2(DMAX + 1),
  localparam int ERR_W = RW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_master,
  input  logic             no_autosw,
  input  logic             fsel_e1,
  input  logic             fsel_8k,
  input  logic             center_dis,
  input  logic             los,
  input  logic             line_edge,
  input  logic             sync_edge,
  input  logic             phase_ready,
  output logic [1:0]       ref_sel,
  output logic             free_run,
  output logic             recenter,
  output logic             phase_valid,
  output logic [ERR_W-1:0] phase_err,
  output logic [ACC_W-1:0] phase_acc
);
  logic          sync_present;
  ref_sel_e      sel;
  logic          sel_chg;
  logic [RW-1:0] ratio;
  logic          wrap;
  logic          ref_edge;

  dco_sync_detect #(.SYNC_WIN(SYNC_WIN)) sync_det_i (
    .clk(clk), .rst(rst), .sync_edge(sync_edge), .present(sync_present)
  );

  dco_ref_select #(.DIV_T1(DIV_T1), .DIV_E1(DIV_E1), .DIV_8K(DIV_8K), .RW(RW)) sel_i (
    .clk(clk), .rst(rst), .mode_master(mode_master), .no_autosw(no_autosw),
    .los(los), .sync_present(sync_present), .fsel_e1(fsel_e1), .fsel_8k(fsel_8k),
    .sel(sel), .sel_chg(sel_chg), .ratio(ratio)
  );

  dco_phase_cmp #(.RW(RW), .ERR_W(ERR_W), .ACC_W(ACC_W)) phase_i (
    .clk(clk), .rst(rst), .ratio(ratio), .sel(sel), .sel_chg(sel_chg),
    .line_edge(line_edge), .sync_edge(sync_edge), .ready(phase_ready),
    .wrap(wrap), .ref_edge(ref_edge), .valid(phase_valid),
    .err(phase_err), .acc(phase_acc)
  );

  dco_center_ctl #(.GAP_PERIODS(GAP_PERIODS)) center_i (
    .clk(clk), .rst(rst), .wrap(wrap), .ref_edge(ref_edge), .sel_chg(sel_chg),
    .sel(sel), .center_dis(center_dis), .recenter(recenter)
  );

  assign ref_sel  = sel;
  assign free_run = (sel == REF_FREE);

  p_free_flag_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_master && !sync_present) |=> free_run);
endmodule

// File: tb/dco_ref_sel_ctl_tb_top.sv
`timescale 1ns/1ps
module dco_ref_sel_ctl_tb_top;
  localparam int WIN = 256;
  localparam int DT1 = 8;
  localparam int DE1 = 6;
  localparam int D8K = 64;
  localparam int GAP = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_master = 0, no_autosw = 0, fsel_e1 = 0, fsel_8k = 0, center_dis = 0, los = 0;
  logic line_edge = 0, sync_edge = 0, phase_ready = 1;
  logic [1:0]  ref_sel;
  logic        free_run, recenter, phase_valid;
  logic [7:0]  phase_err;
  logic [15:0] phase_acc;

  int checks = 0;
  int failures = 0;
  int cyc;
  bit done = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  dco_ref_sel_ctl #(.SYNC_WIN(WIN), .DIV_T1(DT1), .DIV_E1(DE1), .DIV_8K(D8K),
                    .GAP_PERIODS(GAP), .ACC_W(16)) dut_i (
    .clk(clk), .rst(rst), .mode_master(mode_master), .no_autosw(no_autosw),
    .fsel_e1(fsel_e1), .fsel_8k(fsel_8k), .center_dis(center_dis), .los(los),
    .line_edge(line_edge), .sync_edge(sync_edge), .phase_ready(phase_ready),
    .ref_sel(ref_sel), .free_run(free_run), .recenter(recenter),
    .phase_valid(phase_valid), .phase_err(phase_err), .phase_acc(phase_acc)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    step();
    rst = 1'b1; line_edge = 0; sync_edge = 0;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic pulse_line();
    line_edge = 1'b1; step(); line_edge = 1'b0;
  endtask

  task automatic pulse_sync();
    sync_edge = 1'b1; step(); sync_edge = 1'b0;
  endtask

  function automatic int fold(input int k, input int r);
    int p;
    p = k % r;
    return (p < r / 2) ? p : p - r;
  endfunction

  // R6 R7 R10 R11: error at every divider position for one configuration
  task automatic run_phase(input bit m, input bit e1, input bit k8);
    int r, sum, e;
    mode_master = m; fsel_e1 = e1; fsel_8k = k8; los = 0; no_autosw = 0; phase_ready = 1;
    do_reset();
    r = (m && k8) ? D8K : (e1 ? DE1 : DT1);
    if (m) begin
      pulse_sync(); step(); step(); step();
      chk(ref_sel == 2'd1, "R4 sync selected", ref_sel, 1);
      pulse_sync();
      chk(phase_valid == 1'b0, "R10 first edge blanked", phase_valid, 0);
      chk(phase_acc == 16'd0, "R10 acc cleared", phase_acc, 0);
    end
    sum = 0;
    for (int i = 0; i < r; i++) begin
      while ((cyc % r) != i) step();
      e = fold(cyc, r);
      sum += e;
      if (m) pulse_sync(); else pulse_line();
      chk(phase_valid == 1'b1, "R7 valid after edge", phase_valid, 1);
      chk($signed(phase_err) == e, "R6 phase error", $signed(phase_err), e);
      chk($signed(phase_acc) == sum, "R11 accumulator", $signed(phase_acc), sum);
    end
    step();
    chk(phase_valid == 1'b0, "R7 valid falls", phase_valid, 0);
  endtask

  initial begin
    int ex, p0, e0, wr, exp_rc;
    // reset state
    step(); step();
    chk(ref_sel == 2'd0, "R1 reset selection", ref_sel, 0);
    chk(phase_valid == 1'b0, "R7 reset valid", phase_valid, 0);
    chk(phase_acc == 16'd0, "R11 reset acc", phase_acc, 0);

    // R1 R2 R3 R4 R9: full sweep of selection controls
    for (int m = 0; m < 2; m++)
      for (int l = 0; l < 2; l++)
        for (int d = 0; d < 2; d++)
          for (int p = 0; p < 2; p++)
            for (int c = 0; c < 2; c++) begin
              mode_master = m[0]; los = l[0]; no_autosw = d[0]; center_dis = c[0];
              fsel_e1 = 0; fsel_8k = 0;
              do_reset();
              if (p != 0) pulse_sync();
              step(); step(); step();
              if (!(m != 0 || (l != 0 && d == 0))) ex = 0;
              else if (p != 0) ex = 1;
              else ex = 2;
              chk(ref_sel == ex[1:0], "R1 R2 R3 R4 selection", ref_sel, ex);
              chk(free_run == (ex == 2), "R4 free_run flag", free_run, (ex == 2));
              if (ex == 2)
                chk(recenter == (c == 0), "R9 centering in free run", recenter, (c == 0));
            end
    center_dis = 0;

    // R6 R7 R10 R11 across every ratio
    run_phase(0, 0, 0);
    run_phase(0, 1, 0);
    run_phase(0, 0, 1);   // R6: 8 kHz select ignored on the line reference
    run_phase(1, 0, 1);
    run_phase(1, 1, 0);

    // R5: window boundary
    mode_master = 1; los = 0; fsel_8k = 0; fsel_e1 = 0;
    do_reset();
    step(); step();
    p0 = cyc; pulse_sync();
    step();
    chk(ref_sel == 2'd1, "R5 present after strobe", ref_sel, 1);
    while (cyc < p0 + WIN + 1) step();
    chk(ref_sel == 2'd1, "R5 still present at window", ref_sel, 1);
    step();
    chk(ref_sel == 2'd2, "R5 absent after window", ref_sel, 2);
    do_reset();
    step();
    p0 = cyc; pulse_sync();
    while (cyc < p0 + WIN) step();
    pulse_sync();
    while (cyc < p0 + WIN + 3) step();
    chk(ref_sel == 2'd1, "R5 strobes at exact window keep presence", ref_sel, 1);

    // R7: back-pressure
    mode_master = 0; fsel_e1 = 0; phase_ready = 0;
    do_reset();
    while ((cyc % DT1) != 2) step();
    pulse_line();
    chk(phase_valid && $signed(phase_err) == 2, "R7 first result", $signed(phase_err), 2);
    step(); step();
    chk(phase_valid && $signed(phase_err) == 2, "R7 held while not ready", $signed(phase_err), 2);
    while ((cyc % DT1) != 5) step();
    pulse_line();
    chk($signed(phase_err) == 2, "R7 edge dropped while held", $signed(phase_err), 2);
    chk($signed(phase_acc) == 2, "R7 acc unchanged by dropped edge", $signed(phase_acc), 2);
    phase_ready = 1;
    step();
    chk(phase_valid == 1'b0, "R7 accepted and cleared", phase_valid, 0);

    // R10: change of selection clears accumulator
    while ((cyc % DT1) != 3) step();
    pulse_line();
    chk($signed(phase_acc) == 5, "R11 acc sum", $signed(phase_acc), 5);
    los = 1; no_autosw = 0;
    step(); step();
    chk(ref_sel == 2'd2, "R2 fallback to free run", ref_sel, 2);
    chk(phase_acc == 16'd0, "R10 acc cleared on change", phase_acc, 0);
    chk(phase_valid == 1'b0, "R10 valid dropped on change", phase_valid, 0);
    los = 0;

    // R8: gap re-centering, enabled and disabled
    for (int c = 0; c < 2; c++) begin
      mode_master = 0; los = 0; fsel_e1 = 0; center_dis = c[0];
      do_reset();
      repeat (20) step();
      e0 = cyc; pulse_line();
      for (int j = 0; j < 41; j++) begin
        wr = 0;
        for (int k = e0 + 1; k <= cyc - 1; k++)
          if ((k % DT1) == DT1 - 1) wr++;
        exp_rc = (c == 0 && wr >= GAP) ? 1 : 0;
        chk(recenter == exp_rc[0], "R8 gap re-center", recenter, exp_rc);
        step();
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule